// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a small single-accumulator processor. It has its own 4096-word by 16-bit memory, which holds both program and data. It runs each instruction in two clock cycles. In the first cycle it reads the word at the program counter into the instruction register. In the second cycle it decodes the top four bits of that word as the operation. The low twelve bits are a direct memory address, which selects the operand or the store target.

A 12-bit multiplexer drives the memory read address. It passes the program counter during the fetch cycle and the instruction's address field during the execute cycle. There is one branch: it jumps to the address field when the accumulator is zero. Four opcode values do nothing.

While reset is held, a preload write port fills the memory so that a program can be placed before execution starts. The accumulator and the program counter are visible at the ports.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and accumulator become zero. After `rst` is released, the first instruction is fetched from address 0.
- R2: While `rst` is high, a rising edge with `ld_we` high writes `ld_data` into memory word `ld_addr`. While `rst` is low, `ld_we` has no effect on memory contents.
- R3: An instruction word carries its opcode in bits 15:12 and a direct address in bits 11:0. Opcode 1 copies the memory word at the address into the accumulator. Opcode 0 writes the accumulator into that memory word, and a later fetch of that word sees the new value.
- R4: Opcode 3 adds the memory word to the accumulator. Opcode 4 subtracts the memory word from the accumulator. Both results wrap modulo 2^16.
- R5: Opcodes 5, 6 and 7 replace the accumulator with its bitwise OR, AND and XOR, respectively, with the memory word.
- R6: Opcodes 8, 9, 10 and 11 invert, increment (wrapping), decrement (wrapping) and clear the accumulator, respectively. They ignore the address field.
- R7: Opcode 2 loads the program counter with the address field when the accumulator is zero. Otherwise it advances the program counter by one. It never alters the accumulator.
- R8: Opcodes 12 to 15 leave the accumulator unchanged and advance the program counter by one.
- R9: Every instruction takes exactly two cycles: a fetch cycle, then an execute cycle. The program counter changes only at the end of the execute cycle, and an increment from 4095 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables preloading |
| ld_we | input | 1 | Preload write enable (acts only during reset) |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word value |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |

## Verification
Two things can happen in the same cycle and must be checked together.

The first is a branch decision at the top of the address space. A not-taken jump, or any sequential step, at address 4095 must wrap the counter to 0. The bench places a jump-if-zero at address 0 that is taken to 4094. It runs the instructions at 4094 and 4095 and then returns to the same jump, which now sees a non-zero accumulator and falls through to address 1. Each program counter value is compared with a bench-side instruction model.

The second is a store whose target is the very next instruction word, followed at once by the fetch of that word. The bench judges this by the accumulator value that the rewritten instruction produces.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int CPU_AW  = 12;
    localparam int CPU_DW  = 16;
    localparam int CPU_OPW = 4;

    typedef enum logic [CPU_OPW-1:0] {
        OP_PUT  = 4'd0,
        OP_GET  = 4'd1,
        OP_BRZ  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_IOR  = 4'd5,
        OP_AND  = 4'd6,
        OP_XOR  = 4'd7,
        OP_INV  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CLR  = 4'd11,
        OP_NOPC = 4'd12,
        OP_NOPD = 4'd13,
        OP_NOPE = 4'd14,
        OP_NOPF = 4'd15
    } opcode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic acc_we;
        logic mem_we;
        logic branch;
    } ctl_t;

    function automatic ctl_t decode(opcode_e op);
        ctl_t c;
        c = '0;
        unique case (op)
            OP_PUT:  c.mem_we = 1'b1;
            OP_BRZ:  c.branch = 1'b1;
            OP_GET, OP_ADD, OP_SUB, OP_IOR, OP_AND, OP_XOR,
            OP_INV, OP_INC, OP_DEC, OP_CLR:
                     c.acc_we = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int AW = acc_cpu_pkg::CPU_AW,
    parameter int DW = acc_cpu_pkg::CPU_DW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DW = acc_cpu_pkg::CPU_DW
) (
    input  acc_cpu_pkg::opcode_e op,
    input  logic [DW-1:0]        acc,
    input  logic [DW-1:0]        opnd,
    output logic [DW-1:0]        result
);
    import acc_cpu_pkg::*;

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        unique case (op)
            OP_GET:  result = opnd;
            OP_ADD:  result = acc + opnd;
            OP_SUB:  result = acc - opnd;
            OP_IOR:  result = acc | opnd;
            OP_AND:  result = acc & opnd;
            OP_XOR:  result = acc ^ opnd;
            OP_INV:  result = ~acc;
            OP_INC:  result = acc + ONE;
            OP_DEC:  result = acc - ONE;
            OP_CLR:  result = '0;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq #(
    parameter int AW  = acc_cpu_pkg::CPU_AW,
    parameter int DW  = acc_cpu_pkg::CPU_DW,
    parameter int OPW = acc_cpu_pkg::CPU_OPW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DW-1:0]         fetch_word,
    input  logic                  acc_zero,
    output acc_cpu_pkg::phase_e   phase_o,
    output acc_cpu_pkg::opcode_e  op_o,
    output logic [AW-1:0]         field_o,
    output logic [DW-1:0]         ir_o,
    output logic [AW-1:0]         pc_o
);
    import acc_cpu_pkg::*;

    phase_e        phase_q;
    logic [DW-1:0] ir_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_next;
    ctl_t          ctl;

    assign op_o    = opcode_e'(ir_q[DW-1 -: OPW]);
    assign field_o = ir_q[AW-1:0];
    assign ctl     = decode(op_o);
    assign pc_next = (ctl.branch && acc_zero) ? field_o : pc_q + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            ir_q    <= '0;
            pc_q    <= '0;
        end else begin
            unique case (phase_q)
                PH_FETCH: begin
                    ir_q    <= fetch_word;
                    phase_q <= PH_EXEC;
                end
                default: begin
                    pc_q    <= pc_next;
                    phase_q <= PH_FETCH;
                end
            endcase
        end
    end

    assign phase_o = phase_q;
    assign ir_o    = ir_q;
    assign pc_o    = pc_q;
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core #(
    parameter int AW  = acc_cpu_pkg::CPU_AW,
    parameter int DW  = acc_cpu_pkg::CPU_DW,
    parameter int OPW = acc_cpu_pkg::CPU_OPW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] acc_o,
    output logic [AW-1:0] pc_o
);
    import acc_cpu_pkg::*;

    phase_e        phase;
    opcode_e       op;
    ctl_t          ctl;
    logic [AW-1:0] field;
    logic [DW-1:0] ir;
    logic [AW-1:0] pc;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] alu_out;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_raddr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          in_exec;

    assign in_exec = (phase == PH_EXEC);
    assign ctl     = decode(op);

    // address multiplexer: program counter in fetch, operand field in execute
    assign mem_raddr = in_exec ? field : pc;

    // write port: preload owns it during reset, stores own it otherwise
    always_comb begin
        if (rst) begin
            mem_we    = ld_we;
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end else begin
            mem_we    = in_exec && ctl.mem_we;
            mem_waddr = field;
            mem_wdata = acc_q;
        end
    end

    acc_cpu_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    acc_cpu_seq #(.AW(AW), .DW(DW), .OPW(OPW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .fetch_word (mem_rdata),
        .acc_zero   (acc_q == '0),
        .phase_o    (phase),
        .op_o       (op),
        .field_o    (field),
        .ir_o       (ir),
        .pc_o       (pc)
    );

    acc_cpu_alu #(.DW(DW)) u_alu (
        .op     (op),
        .acc    (acc_q),
        .opnd   (mem_rdata),
        .result (alu_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (in_exec && ctl.acc_we) begin
            acc_q <= alu_out;
        end
    end

    assign acc_o = acc_q;
    assign pc_o  = pc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int AW  = acc_cpu_pkg::CPU_AW,
    parameter int DW  = acc_cpu_pkg::CPU_DW,
    parameter int OPW = acc_cpu_pkg::CPU_OPW
) (
    input logic          clk,
    input logic          rst,
    input logic          in_exec,
    input logic [DW-1:0] ir,
    input logic [AW-1:0] pc,
    input logic [DW-1:0] acc
);
    logic [OPW-1:0] opc;
    assign opc = ir[DW-1 -: OPW];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0 && acc == '0 && !in_exec)); // R1

    AST_FETCH_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> $stable(acc)); // R3

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (in_exec && opc == OPW'(2) && acc == '0) |=> (pc == $past(ir[AW-1:0]))); // R7

    AST_BRANCH_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (in_exec && opc == OPW'(2)) |=> $stable(acc)); // R7

    AST_IDLE_OPS: assert property (@(posedge clk) disable iff (rst)
        (in_exec && opc >= OPW'(12)) |=> $stable(acc)); // R8

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_exec && opc != OPW'(2)) |=> (pc == AW'($past(pc) + AW'(1)))); // R9

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> $stable(pc)); // R9

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (rst)
        in_exec |=> !in_exec); // R9
endmodule

bind acc_cpu_core acc_cpu_chk #(.AW(AW), .DW(DW), .OPW(OPW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_exec (in_exec),
    .ir      (ir),
    .pc      (pc),
    .acc     (acc_q)
);

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] acc;
    logic [AW-1:0] pc;

    always #4 clk = ~clk;

    acc_cpu_core dut (
        .clk (clk), .rst (rst), .ld_we (ld_we), .ld_addr (ld_addr),
        .ld_data (ld_data), .acc_o (acc), .pc_o (pc)
    );

    typedef struct {
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ref_acc;
    logic [AW-1:0] ref_pc;

    function automatic logic [DW-1:0] ins(int op, int a);
        return {op[3:0], a[11:0]};
    endfunction

    task automatic put(int a, logic [DW-1:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a[AW-1:0]; ld_data = w;
        ref_mem[a] = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic model_step(string tag);
        logic [DW-1:0] w;
        logic [AW-1:0] a, nxt;
        exp_t e;
        w = ref_mem[ref_pc];
        a = w[AW-1:0];
        nxt = ref_pc + 12'd1;
        case (w[15:12])
            4'd0: ref_mem[a] = ref_acc;
            4'd1: ref_acc = ref_mem[a];
            4'd2: if (ref_acc == 16'd0) nxt = a;
            4'd3: ref_acc = ref_acc + ref_mem[a];
            4'd4: ref_acc = ref_acc - ref_mem[a];
            4'd5: ref_acc = ref_acc | ref_mem[a];
            4'd6: ref_acc = ref_acc & ref_mem[a];
            4'd7: ref_acc = ref_acc ^ ref_mem[a];
            4'd8: ref_acc = ~ref_acc;
            4'd9: ref_acc = ref_acc + 16'd1;
            4'd10: ref_acc = ref_acc - 16'd1;
            4'd11: ref_acc = 16'd0;
            default: ;
        endcase
        ref_pc = nxt;
        e.pc = nxt; e.acc = ref_acc; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic reset_check();
        repeat (2) @(negedge clk);
        n_run++;
        if (pc !== '0 || acc !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: pc=%h acc=%h expected pc=000 acc=0000", pc, acc);
        end
    endtask

    // poke: drive the preload port while running (must be ignored, R2)
    task automatic run(int steps, string tag, bit poke);
        ref_acc = '0; ref_pc = '0;
        for (int i = 0; i < steps; i++) model_step(tag);
        @(negedge clk); #1 rst = 1'b0;
        if (poke) begin
            ld_we = 1'b1; ld_addr = 12'd130; ld_data = 16'hDEAD;
            repeat (3) @(negedge clk);
            ld_we = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk); #1 rst = 1'b1;
        reset_check();
    endtask

    // monitor: one compare per instruction, two edges after the previous one
    initial begin
        bit ph = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst) ph = 1'b0;
            else if (sb_q.size() != 0) begin
                if (ph) begin
                    e = sb_q.pop_front();
                    n_run++;
                    if (pc !== e.pc || acc !== e.acc) begin
                        n_fail++;
                        $display("FAIL %s: pc=%h acc=%h expected pc=%h acc=%h",
                                 e.tag, pc, acc, e.pc, e.acc);
                    end
                    ph = 1'b0;
                end else ph = 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) put(i, ins(12, i));
        reset_check();

        // R3 R4: load, add with wrap, store, subtract with wrap, reload
        put(0, ins(1, 100)); put(1, ins(3, 101)); put(2, ins(0, 102));
        put(3, ins(4, 103)); put(4, ins(1, 102)); put(5, ins(12, 0));
        put(100, 16'hFFF0); put(101, 16'h0020); put(103, 16'h0011);
        run(6, "R4 add/sub/store", 1'b0);

        // R5 logic ops
        put(0, ins(1, 110)); put(1, ins(5, 111)); put(2, ins(6, 112));
        put(3, ins(7, 113));
        put(110, 16'hF0F0); put(111, 16'h0FF0); put(112, 16'h3C3C); put(113, 16'hFFFF);
        run(4, "R5 or/and/xor", 1'b0);

        // R6 unary ops with non-zero address fields
        put(0, ins(11, 12'hABC)); put(1, ins(10, 12'h777)); put(2, ins(9, 12'h0FF));
        put(3, ins(9, 12'hFFF)); put(4, ins(8, 12'h123));
        run(5, "R6 clr/dec/inc/inv", 1'b0);

        // R7 R8: taken jump, untaken jump, four idle opcodes
        put(0, ins(11, 0)); put(1, ins(2, 50)); put(50, ins(9, 0));
        put(51, ins(2, 10)); put(52, ins(13, 1)); put(53, ins(14, 2));
        put(54, ins(15, 3)); put(55, ins(12, 4));
        run(8, "R7 R8 branch/idle", 1'b0);

        // R9 program counter wrap at the top of memory
        put(0, ins(2, 4094)); put(1, ins(12, 0)); put(4094, ins(1, 120));
        put(4095, ins(9, 0)); put(120, 16'h4001);
        run(5, "R9 pc wrap", 1'b0);

        // R2 preload ignored while running
        put(0, ins(12, 0)); put(1, ins(1, 130)); put(2, ins(12, 0)); put(130, 16'h1234);
        run(3, "R2 preload ignored", 1'b1);

        // R3 store rewrites the next instruction word before its fetch
        put(0, ins(1, 140)); put(1, ins(0, 2)); put(2, ins(11, 0)); put(140, ins(9, 0));
        run(3, "R3 store then fetch", 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule